// File: doc/BRIEF.md
# Sparse-Tap One-Bit Linear-Phase Low-Pass Filter

This block smooths a one-bit oversampled stream, such as the output of a noise-shaping modulator, into a signed multi-bit word. It takes one bit on every clock and keeps the most recent bits in a long binary shift register. Only every DEC-th position of that register carries a weight. The impulse response is even about its centre, so each tapped position is paired with its mirror image. Each pair then selects plus its stored coefficient, zero, or minus it. The centre position selects plus or minus its coefficient on its own. Because the stored samples are single bits, the weighted sum needs only adders and subtractors.

The default build has 32 stored coefficients and a decimation factor of 12. This gives a shift register of 745 positions, 63 tapped positions and a centre at position 372. The coefficients are a parameter array. In the default set the largest weight is about 224 times the smallest. A registered sum appears on every clock, and a flag goes high once the register holds only bits received since reset.

Top module: `sparse_fir_1b`

## Requirements
- R1: On every clock edge without reset, `bit_in` enters shift position 0 and each position p takes the previous value of position p-1. The line has 2*(NCOEF-1)*DEC+1 positions, which is 745 by default.
- R2: Only positions that are whole multiples of DEC (0, 12, ..., 744 by default) affect `sum_out`. A bit held at any other position has no effect on the output.
- R3: For pair index k from 0 to NCOEF-2, positions k*DEC and 744-k*DEC are combined. If both hold 1 the pair adds +COEFS[k]. If both hold 0 it adds -COEFS[k]. If the two bits differ it adds 0.
- R4: The centre position (NCOEF-1)*DEC, 372 by default, contributes +COEFS[NCOEF-1] when it holds 1 and -COEFS[NCOEF-1] when it holds 0.
- R5: `sum_out` is the sum of all NCOEF contributions, registered once. After an edge it reflects the line that includes the bit taken at that edge.
- R6: `sum_out` is wide enough that its magnitude never exceeds the sum of |COEFS[i]|. An all-ones line gives exactly +sum(COEFS) and an all-zeros line gives exactly -sum(COEFS).
- R7: `sum_valid` is 0 from reset until the edge that accepts the 745th bit after reset. It is 1 from that edge on and stays 1 until the next reset.
- R8: A synchronous active-high reset loads position p with (p odd) XOR (p >= 372). This puts 0 on every tapped position below the centre and 1 on the centre and on every tapped position above it. All pairs then give 0, so `sum_out` after reset equals +COEFS[NCOEF-1] (13000 by default) and `sum_valid` is 0.
- R9: A reset asserted in the middle of a stream restarts the fill count. `sum_valid` stays 0 for the next 744 accepted bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | One-bit stream sample, 1 meaning +1 and 0 meaning -1 |
| sum_out | output | OUT_W (22) | Signed weighted sum of the folded taps |
| sum_valid | output | 1 | High once the line is filled with fresh bits |

## Verification
A stuck or misrouted bit in the shift register shows up at `sum_out` as soon as that bit reaches a tapped position. This is at most DEC-1 edges after it enters, and the error stays visible until the bit leaves the line 745 edges later. A wrong mirror pairing or a wrong zero selection moves the sum by a full coefficient on the first edge at which the two mirrored bits differ. The reset pattern check and the single-one walk expose this within one line length. A fill counter that is off by one moves the rise of `sum_valid` by one edge, and this is observed at the 744th and 745th bits.

// File: rtl/sptap_pkg.sv
package sptap_pkg;

    localparam int COEF_W    = 16;
    localparam int DEF_NCOEF = 32;
    localparam int DEF_DEC   = 12;

    typedef logic signed [COEF_W-1:0] coef_t;

    // Three-level selection produced by a folded tap pair
    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b10
    } lvl_e;

    // Default weights, smallest at the outer pair, largest at the centre
    localparam coef_t DEF_COEFS [DEF_NCOEF] = '{
        16'sd58,   16'sd70,   16'sd86,   16'sd106,  16'sd130,  16'sd160,
        16'sd196,  16'sd240,  16'sd292,  16'sd354,  16'sd428,  16'sd514,
        16'sd614,  16'sd730,  16'sd864,  16'sd1018, 16'sd1194, 16'sd1394,
        16'sd1620, 16'sd1874, 16'sd2158, 16'sd2474, 16'sd2824, 16'sd3210,
        16'sd3634, 16'sd4098, 16'sd4604, 16'sd5154, 16'sd5750, 16'sd6394,
        16'sd7088, 16'sd13000
    };

    function automatic int line_len(input int ncoef, input int dec);
        return 2 * (ncoef - 1) * dec + 1;
    endfunction

    // Both +1 -> positive, both -1 -> negative, mixed -> cancels
    function automatic lvl_e fold_pair(input logic a, input logic b);
        if (a && b)        return LVL_POS;
        else if (!a && !b) return LVL_NEG;
        else               return LVL_ZERO;
    endfunction

    function automatic lvl_e centre_lvl(input logic a);
        return a ? LVL_POS : LVL_NEG;
    endfunction

    // Alternating bits with the phase flipped at the centre
    function automatic logic reset_bit(input int pos, input int centre);
        return logic'((pos % 2) == 1) ^ logic'(pos >= centre);
    endfunction

endpackage

// File: rtl/sptap_delay_line.sv
module sptap_delay_line
    import sptap_pkg::*;
#(
    parameter int LEN    = 745,
    parameter int CENTRE = 372
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_in,
    output logic [LEN-1:0] line_next
);

    logic [LEN-1:0] line_q;
    logic [LEN-1:0] rst_pat;

    for (genvar p = 0; p < LEN; p++) begin : g_rst_pat
        assign rst_pat[p] = reset_bit(p, CENTRE);
    end

    always_comb begin
        if (rst) line_next = rst_pat;
        else     line_next = {line_q[LEN-2:0], bit_in};
    end

    always_ff @(posedge clk) begin
        line_q <= line_next;
    end

    // R1: new bit lands at the head, the tail moves by one place
    a_r1_shift: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (line_q[0] == $past(bit_in)) &&
                 (line_q[LEN-1] == $past(line_q[LEN-2])));

endmodule

// File: rtl/sptap_fold.sv
module sptap_fold
    import sptap_pkg::*;
#(
    parameter int NCOEF = 32,
    parameter int DEC   = 12,
    parameter int LEN   = 745
) (
    input  logic [LEN-1:0] line,
    output lvl_e           sel [NCOEF]
);

    localparam int NPAIR = NCOEF - 1;
    localparam int CPOS  = NPAIR * DEC;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int NEAR = k * DEC;
        localparam int FAR  = LEN - 1 - k * DEC;
        assign sel[k] = fold_pair(line[NEAR], line[FAR]);
    end

    assign sel[NPAIR] = centre_lvl(line[CPOS]);

endmodule

// File: rtl/sptap_accum.sv
module sptap_accum
    import sptap_pkg::*;
#(
    parameter int    NCOEF         = 32,
    parameter int    OUT_W         = 22,
    parameter coef_t COEFS [NCOEF] = DEF_COEFS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  lvl_e                    sel [NCOEF],
    output logic signed [OUT_W-1:0] sum_q
);

    localparam int EXT = OUT_W - COEF_W;

    logic signed [OUT_W-1:0] acc;
    logic signed [OUT_W-1:0] bound;
    logic [2*NCOEF-1:0]      sel_flat;

    for (genvar i = 0; i < NCOEF; i++) begin : g_flat
        assign sel_flat[2*i +: 2] = sel[i];
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NCOEF; i++) begin
            case (sel[i])
                LVL_POS: acc = acc + {{EXT{COEFS[i][COEF_W-1]}}, COEFS[i]};
                LVL_NEG: acc = acc - {{EXT{COEFS[i][COEF_W-1]}}, COEFS[i]};
                default: acc = acc;
            endcase
        end
    end

    // Reset reaches the sum through the reset pattern of the line
    always_ff @(posedge clk) begin
        sum_q <= acc;
    end

    always_comb begin
        bound = '0;
        for (int i = 0; i < NCOEF; i++) begin
            if (COEFS[i] < 0) bound = bound - {{EXT{COEFS[i][COEF_W-1]}}, COEFS[i]};
            else              bound = bound + {{EXT{COEFS[i][COEF_W-1]}}, COEFS[i]};
        end
    end

    // R6: magnitude never exceeds the sum of coefficient magnitudes
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (sum_q <= bound) && (sum_q >= -bound));

    // R2: with the tap selections unchanged the output cannot move
    a_r2_taps_only: assert property (@(posedge clk) disable iff (rst)
        (!rst && $stable(sel_flat)) |=> $stable(sum_q));

endmodule

// File: rtl/sptap_fill.sv
module sptap_fill
    import sptap_pkg::*;
#(
    parameter int LEN = 745
) (
    input  logic clk,
    input  logic rst,
    output logic valid_q
);

    localparam int CNT_W = $clog2(LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) valid_q <= 1'b1;
        end
    end

    // R7: once set, valid holds until reset
    a_r7_valid_hold: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q);

    // R7: valid rises only on the edge taking the last fill bit
    a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> ($past(cnt_q) == LAST));

    // R9: a reset always drops valid on the following edge
    a_r9_restart: assert property (@(posedge clk)
        rst |=> !valid_q);

endmodule

// File: rtl/sparse_fir_1b.sv
module sparse_fir_1b
    import sptap_pkg::*;
#(
    parameter int    NCOEF         = DEF_NCOEF,
    parameter int    DEC           = DEF_DEC,
    parameter coef_t COEFS [NCOEF] = DEF_COEFS,
    localparam int   LEN           = line_len(NCOEF, DEC),
    localparam int   CENTRE        = (NCOEF - 1) * DEC,
    localparam int   OUT_W         = COEF_W + $clog2(NCOEF) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_in,
    output logic signed [OUT_W-1:0] sum_out,
    output logic                    sum_valid
);

    logic [LEN-1:0] line_next;
    lvl_e           sel [NCOEF];

    sptap_delay_line #(.LEN(LEN), .CENTRE(CENTRE)) u_line (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (bit_in),
        .line_next(line_next)
    );

    sptap_fold #(.NCOEF(NCOEF), .DEC(DEC), .LEN(LEN)) u_fold (
        .line(line_next),
        .sel (sel)
    );

    sptap_accum #(.NCOEF(NCOEF), .OUT_W(OUT_W), .COEFS(COEFS)) u_accum (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel),
        .sum_q(sum_out)
    );

    sptap_fill #(.LEN(LEN)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .valid_q(sum_valid)
    );

    // R8: reset state of the sum is the centre weight alone
    a_r8_reset_sum: assert property (@(posedge clk)
        rst |=> (sum_out == OUT_W'(COEFS[NCOEF-1])));

endmodule

// File: tb/sparse_fir_1b_tb.sv
module sparse_fir_1b_tb;
    import sptap_pkg::*;

    localparam int LEN   = 745;
    localparam int NC    = 32;
    localparam int DEC   = 12;
    localparam int CPOS  = 372;
    localparam int OUT_W = 22;

    // Stimulus table: {mode[18:16], bit count[15:0]}
    localparam int NV = 7;
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 16'd800},   // all ones
        {3'd1, 16'd800},   // all zeros
        {3'd2, 16'd400},   // alternating
        {3'd3, 16'd900},   // square wave, period 24
        {3'd4, 16'd1500},  // pseudo-random
        {3'd5, 16'd760},   // single one walking through zeros
        {3'd6, 16'd600}    // 3-of-7 pattern
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic signed [OUT_W-1:0] sum_out;
    logic sum_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic mline [LEN];
    int filled = 0;
    logic [15:0] lfsr = 16'hACE1;
    int total;

    always #2 clk = ~clk;

    sparse_fir_1b u_dut (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (bit_in),
        .sum_out  (sum_out),
        .sum_valid(sum_valid)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_sum();
        int s = 0;
        for (int k = 0; k < NC - 1; k++) begin
            if (mline[k*DEC] && mline[LEN-1-k*DEC])        s += int'(DEF_COEFS[k]);
            else if (!mline[k*DEC] && !mline[LEN-1-k*DEC]) s -= int'(DEF_COEFS[k]);
        end
        s += mline[CPOS] ? int'(DEF_COEFS[NC-1]) : -int'(DEF_COEFS[NC-1]);
        return s;
    endfunction

    task automatic push(input logic b);
        bit_in = b;
        @(posedge clk);
        for (int p = LEN - 1; p > 0; p--) mline[p] = mline[p-1];
        mline[0] = b;
        if (filled < LEN) filled++;
        #1;
        chk("R5 sum", longint'(sum_out), longint'(model_sum()));
        chk("R7 valid", longint'(sum_valid), longint'(filled >= LEN));
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        for (int p = 0; p < LEN; p++) mline[p] = logic'(p % 2 == 1) ^ logic'(p >= CPOS);
        filled = 0;
        #1;
        chk("R8 reset sum", longint'(sum_out), longint'(DEF_COEFS[NC-1]));
        chk("R8 reset valid", longint'(sum_valid), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic gen(input int mode, input int i);
        case (mode)
            0: return 1'b1;
            1: return 1'b0;
            2: return logic'(i % 2);
            3: return logic'((i % 24) < 12);
            4: return lfsr[0];
            5: return logic'(i == 0);
            default: return logic'((i % 7) < 3);
        endcase
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        total = 0;
        for (int i = 0; i < NC; i++) total += int'(DEF_COEFS[i]);
        @(negedge clk);
        do_reset();

        // R7: valid low through the 744th bit, high on the 745th
        for (int i = 0; i < LEN - 1; i++) push(1'b0);
        chk("R7 valid before fill", longint'(sum_valid), 0);
        push(1'b0);
        chk("R7 valid at fill", longint'(sum_valid), 1);
        chk("R6 all zeros", longint'(sum_out), -longint'(total));

        // R2: a lone one at untapped position 4 leaves the sum unchanged
        push(1'b1);
        for (int i = 0; i < 4; i++) push(1'b0);
        chk("R2 untapped", longint'(sum_out), -longint'(total));

        // R3: one at position 12 against zero at its mirror gives a zero pair
        for (int i = 0; i < 8; i++) push(1'b0);
        chk("R3 pair cancel", longint'(sum_out),
            -longint'(total) + longint'(DEF_COEFS[1]));

        // R4: the same one reaching the centre flips only the centre sign
        for (int i = 0; i < CPOS - 12; i++) push(1'b0);
        chk("R4 centre", longint'(sum_out),
            -longint'(total) + 2 * longint'(DEF_COEFS[NC-1]));

        // R6: all-ones line gives the positive maximum
        for (int i = 0; i < LEN; i++) push(1'b1);
        chk("R6 all ones", longint'(sum_out), longint'(total));

        // R9: reset in mid-stream restarts the fill count
        do_reset();
        for (int i = 0; i < 100; i++) push(1'b1);
        chk("R9 valid after restart", longint'(sum_valid), 0);

        // Table walk
        do_reset();
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < int'(VEC[v][15:0]); i++) begin
                push(gen(int'(VEC[v][18:16]), i));
                lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            end
        end

        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        report();
    end

endmodule